// File: doc/BRIEF.md
# Inter-Access Gap Timer

This block sits between an access queue and the pin sequencer of an external memory controller with four chip-selects. It decides how many idle functional-clock cycles must pass between the end of one access and the start of the next. While that idle gap runs, every chip-select stays deasserted. The block then grants the waiting request and asserts that request's chip-select until the sequencer reports that the access is complete.

The gap depends on two things: the access that just finished, as recorded at its grant, and the request that is waiting. Two delay sources can apply. The first is a chip-select-high delay. It has one enable for consecutive accesses to the same chip-select and another for accesses to different chip-selects. The second is a bus-turnaround delay, which applies after reads. When both apply, their counts add. All timing fields come from the configuration set of the incoming request's chip-select. A small write port loads one chip-select's set per cycle.

Top module: `access_gap_timer`

## Requirements
- R1: After reset every `cs_n` bit is 1, `grant` is 0, and every configuration field is 0. With that configuration, a request waiting when `done` is seen is granted in the very next cycle.
- R2: The first request after reset has no previous access to compare with. It is granted in the cycle it is presented while the block is idle.
- R3: `grant` is high only while `req_valid` is high and no access is active. Let `done` be high in cycle t and let the required gap be G. A request that is waiting is then granted in cycle t+1+G. Every idle cycle that has already passed since `done` counts toward G.
- R4: After a grant, `cs_n[req_cs]` (bit i for chip-select i) goes to 0 in the next cycle and stays 0 up to and including the cycle in which `done` is high. At all other times every `cs_n` bit is 1. At most one bit is 0 at any time.
- R5: When the previous and the new access use the same chip-select, the chip-select-high count is added only if that chip-select's same-select enable is 1. The access types do not matter.
- R6: When the previous and the new access use different chip-selects, the chip-select-high count is added only if the new chip-select's different-select enable is 1. The access types do not matter.
- R7: The turnaround count is added in two cases: a read followed by a write on the same chip-select, and a read followed by any access on a different chip-select.
- R8: No turnaround is added in three cases: a write followed by any access, a read followed by a read on the same chip-select, and a write followed by a read on the same chip-select.
- R9: When turnaround and chip-select-high both apply, the gap is their sum, up to 30 cycles.
- R10: With `cfg_we` high, the fields are written to the set of chip-select `cfg_sel` and take effect from the next cycle. Only the set belonging to the incoming request's chip-select decides its gap.
- R11: The chip-select and the read/write type (`req_write` 1 = write) of each access are recorded when it is granted. That record classifies the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for one configuration set |
| cfg_sel | input | 2 | Chip-select whose set is written |
| cfg_csh_dly | input | 4 | Chip-select-high delay count, 0 to 15 cycles |
| cfg_same_en | input | 1 | Enable the chip-select-high delay between accesses to the same chip-select |
| cfg_diff_en | input | 1 | Enable the chip-select-high delay between accesses to different chip-selects |
| cfg_turn | input | 4 | Bus-turnaround count, 0 to 15 cycles |
| req_valid | input | 1 | A request is waiting; held until granted |
| req_cs | input | 2 | Chip-select index of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| grant | output | 1 | Request accepted in this cycle |
| done | input | 1 | Active access completes in this cycle |
| cs_n | output | 4 | Active-low chip-selects |

## Verification
The bench focuses on how each transition is classified. It covers write-then-read on the same chip-select, which must not pick up turnaround, and a read followed by a read on another chip-select, which must. A design that swapped these cases would grant too early or too late by exactly the turnaround count. The bench also checks that the gap is taken from the incoming chip-select's set and not the previous one's, which would show up as the wrong delay. It checks the case where turnaround and chip-select-high both apply, where taking the maximum instead of the sum would grant early. Configuration writes made during the idle time test that elapsed idle cycles count toward the gap; a timer that starts counting only at the request would grant late.

// File: rtl/gap_pkg.sv
package gap_pkg;

    localparam int DLY_W = 4;
    localparam int GAP_W = DLY_W + 1;

    typedef struct packed {
        logic [DLY_W-1:0] csh_dly;
        logic             same_en;
        logic             diff_en;
        logic [DLY_W-1:0] turn;
    } cs_cfg_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } gap_state_e;

endpackage

// File: rtl/gap_cfg_bank.sv
module gap_cfg_bank
    import gap_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = $clog2(NUM_CS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  cs_cfg_t          wdata,
    input  logic [SEL_W-1:0] rsel,
    output cs_cfg_t          rdata
);

    cs_cfg_t bank_d [NUM_CS];
    cs_cfg_t bank_q [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_set
        always_comb begin
            bank_d[g] = bank_q[g];
            if (we && (wsel == SEL_W'(g))) begin
                bank_d[g] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else begin
                bank_q[g] <= bank_d[g];
            end
        end
    end

    assign rdata = bank_q[rsel];

endmodule

// File: rtl/gap_calc.sv
module gap_calc
    import gap_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             has_prev,
    input  logic [SEL_W-1:0] prev_cs,
    input  logic             prev_wr,
    input  logic [SEL_W-1:0] next_cs,
    input  logic             next_wr,
    input  cs_cfg_t          cfg,
    output logic [GAP_W-1:0] gap
);

    logic same_sel;
    logic turn_hit;
    logic csh_hit;
    logic [GAP_W-1:0] turn_part;
    logic [GAP_W-1:0] csh_part;

    always_comb begin
        same_sel  = (prev_cs == next_cs);
        // turnaround only after a read: read->write same select, read->any other select
        turn_hit  = has_prev && !prev_wr && (!same_sel || next_wr);
        csh_hit   = has_prev && (same_sel ? cfg.same_en : cfg.diff_en);
        turn_part = turn_hit ? GAP_W'(cfg.turn) : '0;
        csh_part  = csh_hit ? GAP_W'(cfg.csh_dly) : '0;
        gap       = turn_part + csh_part;
    end

endmodule

// File: rtl/access_gap_timer.sv
module access_gap_timer
    import gap_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DLY_W-1:0]  cfg_csh_dly,
    input  logic              cfg_same_en,
    input  logic              cfg_diff_en,
    input  logic [DLY_W-1:0]  cfg_turn,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_cs,
    input  logic              req_write,
    output logic              grant,
    input  logic              done,
    output logic [NUM_CS-1:0] cs_n
);

    typedef struct packed {
        gap_state_e       st;
        logic [GAP_W-1:0] elapsed;
        logic             has_prev;
        logic [SEL_W-1:0] prev_cs;
        logic             prev_wr;
    } tmr_state_t;

    tmr_state_t s_d;
    tmr_state_t s_q;

    cs_cfg_t          wr_cfg;
    cs_cfg_t          req_cfg;
    logic [GAP_W-1:0] need_gap;

    assign wr_cfg = '{csh_dly: cfg_csh_dly, same_en: cfg_same_en,
                      diff_en: cfg_diff_en, turn: cfg_turn};

    gap_cfg_bank #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wsel  (cfg_sel),
        .wdata (wr_cfg),
        .rsel  (req_cs),
        .rdata (req_cfg)
    );

    gap_calc #(.SEL_W(SEL_W)) i_calc (
        .has_prev (s_q.has_prev),
        .prev_cs  (s_q.prev_cs),
        .prev_wr  (s_q.prev_wr),
        .next_cs  (req_cs),
        .next_wr  (req_write),
        .cfg      (req_cfg),
        .gap      (need_gap)
    );

    always_comb begin
        s_d   = s_q;
        grant = 1'b0;
        cs_n  = '1;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid && (s_q.elapsed >= need_gap)) begin
                    grant       = 1'b1;
                    s_d.st      = ST_ACTIVE;
                    s_d.has_prev = 1'b1;
                    s_d.prev_cs = req_cs;
                    s_d.prev_wr = req_write;
                end else if (s_q.elapsed != '1) begin
                    s_d.elapsed = s_q.elapsed + 1'b1;
                end
            end
            ST_ACTIVE: begin
                cs_n[s_q.prev_cs] = 1'b0;
                if (done) begin
                    s_d.st      = ST_IDLE;
                    s_d.elapsed = '0;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, elapsed: '0, has_prev: 1'b0,
                     prev_cs: '0, prev_wr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/gap_timer_checker.sv
module gap_timer_checker #(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [SEL_W-1:0]  req_cs,
    input logic              grant,
    input logic              done,
    input logic [NUM_CS-1:0] cs_n
);

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> req_valid); // R3

    AST_GRANT_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (&cs_n)); // R4

    AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R4

    AST_SELECT_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !cs_n[$past(req_cs)]); // R4

    AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(&cs_n)) |=> (&cs_n)); // R4

    AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !done) |=> $stable(cs_n)); // R4

endmodule

bind access_gap_timer gap_timer_checker #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_cs    (req_cs),
    .grant     (grant),
    .done      (done),
    .cs_n      (cs_n)
);

// File: tb/test_access_gap_timer.sv
module test_access_gap_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NCS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [3:0] cfg_csh_dly = '0;
    logic       cfg_same_en = 1'b0;
    logic       cfg_diff_en = 1'b0;
    logic [3:0] cfg_turn = '0;
    logic       req_valid = 1'b0;
    logic [1:0] req_cs = '0;
    logic       req_write = 1'b0;
    logic       grant;
    logic       done = 1'b0;
    logic [3:0] cs_n;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench model of configuration and history
    int  m_dly [NCS];
    bit  m_same [NCS];
    bit  m_diff [NCS];
    int  m_turn [NCS];
    bit  m_has_prev = 1'b0;
    int  m_prev_cs = 0;
    bit  m_prev_wr = 1'b0;
    int  m_idle = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    access_gap_timer i_access_gap_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_csh_dly (cfg_csh_dly),
        .cfg_same_en (cfg_same_en),
        .cfg_diff_en (cfg_diff_en),
        .cfg_turn    (cfg_turn),
        .req_valid   (req_valid),
        .req_cs      (req_cs),
        .req_write   (req_write),
        .grant       (grant),
        .done        (done),
        .cs_n        (cs_n)
    );

    function automatic int exp_gap(int cs, bit wr);
        int g;
        bit same;
        bit turn_on;
        bit csh_on;
        if (!m_has_prev) return 0;
        same    = (cs == m_prev_cs);
        turn_on = (!m_prev_wr) && (same ? wr : 1'b1);
        csh_on  = same ? m_same[cs] : m_diff[cs];
        g = (turn_on ? m_turn[cs] : 0) + (csh_on ? m_dly[cs] : 0);
        return g;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(int cs, int dly, bit se, bit de, int trn);
        cfg_we = 1'b1;
        cfg_sel = 2'(cs);
        cfg_csh_dly = 4'(dly);
        cfg_same_en = se;
        cfg_diff_en = de;
        cfg_turn = 4'(trn);
        @(negedge clk);
        cfg_we = 1'b0;
        m_dly[cs] = dly; m_same[cs] = se; m_diff[cs] = de; m_turn[cs] = trn;
        m_idle++;
    endtask

    // called just after a falling edge
    task automatic access(int cs, bit wr, int len, string tag);
        int exp;
        int k;
        bit cs_ok;
        exp = exp_gap(cs, wr);
        exp = (exp > m_idle) ? exp - m_idle : 0;
        req_valid = 1'b1;
        req_cs = 2'(cs);
        req_write = wr;
        #1;
        k = 0;
        cs_ok = 1'b1;
        while (!grant && k < 40) begin
            if (cs_n != 4'hF) cs_ok = 1'b0;
            @(negedge clk);
            #1;
            k++;
        end
        check(k == exp, tag, k, exp);
        check(cs_ok, "R4 gap deasserted", int'(cs_ok), 1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(cs_n == ~(4'b1 << cs), "R4 select asserted", int'(cs_n), int'(~(4'b1 << cs) & 4'hF));
        m_has_prev = 1'b1;
        m_prev_cs = cs;
        m_prev_wr = wr;
        repeat (len) @(negedge clk);
        #1;
        check(cs_n == ~(4'b1 << cs), "R4 select held", int'(cs_n), int'(~(4'b1 << cs) & 4'hF));
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        #1;
        check(cs_n == 4'hF, "R4 release", int'(cs_n), 15);
        m_idle = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NCS; i++) begin
            m_dly[i] = 0; m_same[i] = 0; m_diff[i] = 0; m_turn[i] = 0;
        end
        repeat (3) @(negedge clk);
        #1;
        check(cs_n == 4'hF, "R1 reset cs_n", int'(cs_n), 15);
        check(grant == 1'b0, "R1 reset grant", int'(grant), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed: reset configuration
        access(0, 1'b0, 2, "R2 first request no gap");
        access(1, 1'b0, 1, "R1 default read-read other select");
        access(1, 1'b1, 0, "R1 default read-write same select");

        cfg_write(1, 3, 1'b1, 1'b0, 2);
        cfg_write(2, 4, 1'b0, 1'b1, 5);
        cfg_write(3, 0, 1'b0, 1'b0, 6);
        access(1, 1'b1, 1, "R3 idle cycles count toward gap");
        access(1, 1'b1, 1, "R5 same select write-write");
        access(1, 1'b0, 1, "R8 write-read same select");
        access(1, 1'b0, 2, "R8 read-read same select");
        access(1, 1'b1, 0, "R9 read-write same select sum");
        access(2, 1'b0, 1, "R6 different select enable");
        access(3, 1'b0, 1, "R7 read-read other select");
        access(2, 1'b1, 1, "R9 turnaround plus select-high");
        access(2, 1'b1, 1, "R8 write-write same select");
        access(0, 1'b1, 1, "R10 incoming select set used");
        access(3, 1'b1, 1, "R11 history write then other select");
        cfg_write(0, 15, 1'b1, 1'b1, 15);
        access(0, 1'b1, 0, "R6 other select after write");
        access(0, 1'b0, 0, "R5 same select write-read");
        access(0, 1'b1, 0, "R9 maximum sum");

        // random traffic
        for (int n = 0; n < 300; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                cfg_write(int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
                          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                          int'($urandom_range(0, 15)));
            end
            access(int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                   int'($urandom_range(0, 3)), "R3 random gap");
        end

        finish_run();
    end

endmodule